// File: doc/BRIEF.md
# Biphase-Level Manchester Line Encoder

This block turns a serial NRZ bit stream into one biphase-level line signal. It drives a true copy and a complemented copy of that signal. Each bit fills one cell of two equal halves, and the level change in the middle of the cell carries the bit's value. A one is sent high then low, and a zero is sent low then high.

The block runs on a single clock at twice the line baud rate, and an internal half-cell phase divides that clock. The block does not use both edges of a bit clock. The `cell_start` output tells the data source which cycle takes the next bit. The source must present that bit during a cycle where `cell_start` is high, and the bit is taken at the rising edge that closes that cycle. A synchronous active-low reset stops sampling and parks the line at a defined idle level.

Top module: `manchester_bpl_encoder`

## Requirements
- R1: While `rst_n` is sampled low, `tx` goes to the idle level (low by default) and `txb` goes high, and no data is taken. The first cycle after reset has `cell_start` high.
- R2: A sampled one gives `tx` high in the first half-cell and low in the second half-cell.
- R3: A sampled zero gives `tx` low in the first half-cell and high in the second half-cell.
- R4: `data_in` is sampled only at the rising edge that closes a cycle with `cell_start` high. A change of `data_in` in any other cycle has no effect on `tx`.
- R5: The first-half level appears in the cycle right after the sampling edge, and the second-half level appears in the cycle after that. Each half lasts exactly one clock cycle.
- R6: `txb` is the logical complement of `tx` in every cycle.
- R7: Once reset is released, `cell_start` alternates high and low on every clock cycle.
- R8: Between two adjacent cells, `tx` changes level at the cell boundary when the two bits are equal, and keeps its level when they differ.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock at twice the line baud rate |
| rst_n | input | 1 | Synchronous reset, active low |
| data_in | input | 1 | NRZ data bit, taken at the edge closing a `cell_start` cycle |
| cell_start | output | 1 | High in the cycle whose closing edge samples `data_in` |
| tx | output | 1 | Encoded line signal |
| txb | output | 1 | Complement of `tx` |

## Verification
A bit driven during a `cell_start` cycle is sampled one edge later. Its first-half level is due one cycle after that edge, and its second-half level is due one cycle after the first half. The driver stamps each expected half-level with the cycle count in which it is due. The monitor samples a quarter period after each rising edge and compares only entries whose stamp equals the current count. The complement relation, the alternation of `cell_start` and the boundary rule are checked on the same samples. Entries still pending when reset hits are discarded, because reset overrides them.

// File: rtl/menc_pkg.sv
// Shared types for the Manchester encoder.
// Assumes a single clock domain running at twice the baud rate.
package menc_pkg;
    // Which half of the bit cell the current clock cycle belongs to.
    typedef enum logic {
        HALF_A = 1'b0,   // cycle whose closing edge samples a new bit
        HALF_B = 1'b1    // cycle whose closing edge emits the inverted bit
    } half_t;
endpackage

// File: rtl/menc_phase.sv
// Half-cell phase generator: toggles between HALF_A and HALF_B every clock.
// Assumes synchronous active-low reset; reset parks the phase at HALF_A.
module menc_phase
    import menc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    output half_t half
);
    // Advance the phase by one half-cell per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) half <= HALF_A;
        else        half <= (half == HALF_A) ? HALF_B : HALF_A;
    end

    // R7: phase must change on every clock outside reset
    a_r7_phase_alternates: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (half != $past(half)));
endmodule

// File: rtl/menc_cell.sv
// Bit capture and half-cell level selection.
// At a HALF_A edge the incoming bit is stored and is also the next line level.
// At a HALF_B edge the next line level is the complement of the stored bit.
// Assumes data_in is stable around the edge that closes a HALF_A cycle.
module menc_cell
    import menc_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  half_t half,
    input  logic  data_in,
    output logic  level_next
);
    logic held;

    // Store the bit of the current cell at the edge that opens it.
    always_ff @(posedge clk) begin
        if (!rst_n)              held <= 1'b0;
        else if (half == HALF_A) held <= data_in;
    end

    // Pick the level for the half-cell that starts at the coming edge.
    always_comb begin
        level_next = (half == HALF_A) ? data_in : ~held;
    end

    // R4: the stored bit must not change during the second half
    a_r4_hold_in_second_half: assert property (@(posedge clk) disable iff (!rst_n)
        (half == HALF_B) |=> $stable(held));
endmodule

// File: rtl/menc_drive.sv
// Registered line drivers: true and complemented outputs in separate flops,
// so both switch on the same edge with no combinational glitches.
// IDLE_TX sets the true-output level held during reset.
module menc_drive #(
    parameter logic IDLE_TX = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_next,
    output logic tx,
    output logic txb
);
    // True output register.
    always_ff @(posedge clk) begin
        if (!rst_n) tx <= IDLE_TX;
        else        tx <= level_next;
    end

    // Complement output register.
    always_ff @(posedge clk) begin
        if (!rst_n) txb <= ~IDLE_TX;
        else        txb <= ~level_next;
    end

    // R6: the two outputs must always be complements
    a_r6_txb_mirrors: assert property (@(posedge clk) disable iff (!rst_n)
        txb == ~tx);
    // R1: the cycle after reset shows the idle level
    a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (tx == IDLE_TX && txb == ~IDLE_TX));
endmodule

// File: rtl/manchester_bpl_encoder.sv
// Biphase-level Manchester encoder top.
// clk runs at twice the baud rate. A one is sent high then low, and a zero
// low then high. cell_start marks the cycle whose closing edge takes data_in.
module manchester_bpl_encoder
    import menc_pkg::*;
#(
    parameter logic IDLE_TX = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic data_in,
    output logic cell_start,
    output logic tx,
    output logic txb
);
    half_t half;
    logic  level_next;

    menc_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .half  (half)
    );

    menc_cell u_cell (
        .clk        (clk),
        .rst_n      (rst_n),
        .half       (half),
        .data_in    (data_in),
        .level_next (level_next)
    );

    menc_drive #(.IDLE_TX(IDLE_TX)) u_drive (
        .clk        (clk),
        .rst_n      (rst_n),
        .level_next (level_next),
        .tx         (tx),
        .txb        (txb)
    );

    // Tell the source which cycle takes the next bit.
    always_comb begin
        cell_start = (half == HALF_A);
    end

    // R2/R3: the first-half level equals the bit taken at the previous edge
    a_r4_first_half_is_sample: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(half) == HALF_A) |-> (tx == $past(data_in)));
    // R5: the level flips at mid-cell
    a_r5_mid_cell_flip: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(half) == HALF_B && half == HALF_A) |-> (tx == ~$past(tx)));
endmodule

// File: tb/manchester_bpl_encoder_test.sv
// Scoreboard bench: the driver queues expected half-cell levels stamped with
// the cycle in which they are due; the monitor compares them 5 ns after each edge.
module manchester_bpl_encoder_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic data_in = 1'b0;
    logic cell_start, tx, txb;

    manchester_bpl_encoder uut (
        .clk        (clk),
        .rst_n      (rst_n),
        .data_in    (data_in),
        .cell_start (cell_start),
        .tx         (tx),
        .txb        (txb)
    );

    always #10 clk = ~clk;

    int unsigned cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        logic        lvl;
        logic        bitv;
        bit          first;
        int unsigned due;
    } exp_t;
    exp_t q[$];

    int n_run = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input bit ok, input string req, input logic act, input logic exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s at cycle %0d: actual %b expected %b", req, cyc, act, exp);
        end
    endtask

    // Monitor: per-cycle relations plus scoreboard comparisons.
    logic last_rst = 1'b0, last_cs = 1'b0, prev_tx = 1'b0, prev_bit = 1'b0;
    bit have_prev = 1'b0;
    always @(posedge clk) begin
        #5;
        check(txb === ~tx, "R6 txb complement", txb, ~tx);
        if (rst_n && last_rst)
            check(cell_start !== last_cs, "R7 cell_start alternation", cell_start, ~last_cs);
        if (!rst_n) have_prev = 1'b0;
        while (q.size() > 0 && q[0].due == cyc) begin
            exp_t e;
            e = q.pop_front();
            if (e.bitv) check(tx === e.lvl, e.first ? "R2/R5 one first half" : "R2/R5 one second half", tx, e.lvl);
            else        check(tx === e.lvl, e.first ? "R3/R5 zero first half" : "R3/R5 zero second half", tx, e.lvl);
            if (e.first) begin
                if (have_prev)
                    check((tx !== prev_tx) == (e.bitv == prev_bit), "R8 cell boundary",
                          tx !== prev_tx, e.bitv == prev_bit);
                prev_bit  = e.bitv;
                have_prev = 1'b1;
            end
        end
        prev_tx  = tx;
        last_rst = rst_n;
        last_cs  = cell_start;
    end

    // Driver: send one bit; optionally disturb data_in in the second half (R4).
    task automatic send_bit(input logic b, input bit glitch);
        while (!cell_start) @(negedge clk);
        data_in = b;
        q.push_back('{lvl: b,  bitv: b, first: 1'b1, due: cyc + 1});
        q.push_back('{lvl: ~b, bitv: b, first: 1'b0, due: cyc + 2});
        @(negedge clk);
        if (glitch) data_in = ~b;
        @(negedge clk);
    endtask

    // Reset for n cycles while toggling data_in, then check the idle state (R1).
    task automatic do_reset(input int n);
        @(negedge clk);
        rst_n = 1'b0;
        q.delete();
        for (int i = 0; i < n; i++) begin
            data_in = ~data_in;
            @(negedge clk);
        end
        check(tx === 1'b0, "R1 tx idle in reset", tx, 1'b0);
        check(txb === 1'b1, "R1 txb idle in reset", txb, 1'b1);
        check(cell_start === 1'b1, "R1 phase cleared by reset", cell_start, 1'b1);
        data_in = 1'b1;
        rst_n = 1'b1;
    endtask

    initial begin
        do_reset(4);
        send_bit(1'b0, 1'b0);                 // R1/R4: reset-time data_in=1 must not leak
        for (int i = 0; i < 8; i++) send_bit(1'b1, 1'b0);   // R2, R8 equal ones
        for (int i = 0; i < 8; i++) send_bit(1'b0, 1'b0);   // R3, R8 equal zeros
        for (int i = 0; i < 16; i++) send_bit(logic'(i % 2), 1'b0); // R8 differing
        for (int i = 0; i < 16; i++) send_bit(logic'(i % 2), 1'b1); // R4 glitches
        for (int i = 0; i < 300; i++) send_bit(logic'($urandom_range(1)), bit'($urandom_range(1)));
        // Mid-cell reset: enter a second half, then reset.
        while (!cell_start) @(negedge clk);
        data_in = 1'b1;
        @(negedge clk);
        do_reset(3);
        send_bit(1'b1, 1'b0);
        for (int i = 0; i < 50; i++) send_bit(logic'($urandom_range(1)), 1'b1);
        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        #(20 * 150000);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule